// File: doc/BRIEF.md
# Flash Program/Erase Status Responder

This block forms the byte that a parallel NOR flash puts on its data pins when a read arrives while its program/erase engine is busy, suspended or halted by a buffer abort. When the engine is idle, the byte is plain array data. In the other states the byte carries polling, toggle, error, erase-timer, alternative-toggle and abort flags. Their values depend on the operation in progress, on the suspend state and on whether the addressed block is one being erased.

The array, the command decoder and the erase timing sit outside the block. They supply the operation type, the erase and protection bitmaps, the state flags and the array byte. Each read strobe produces a registered result one clock later. Between strobes the output holds its value.

Top module: `flash_status_resp`

## Requirements
- R1: With operation code 0 (idle) and no abort latched, a strobe returns `array_data` on `dq` one cycle later.
- R2: For operation code 1 (program) or 2 (buffer program), bit 7 returns the inverse of `prog_data[7]`. Bits 4, 3 and 0 read 0, and bit 2 holds the value it had before the operation.
- R3: In program or erase status, bit 6 returns the toggle state and then inverts it on every strobe, whatever the block. The first status read after read mode returns 0.
- R4: For operation code 3 (block erase) or 4 (chip erase) without suspend, bit 7 reads 0. Bit 2 returns the alternative-toggle state and inverts it only when the addressed block is set in `erase_map` and clear in `prot_map`. Otherwise bit 2 holds.
- R5: Bit 3 reads `erase_started` during block erase and reads 1 during chip erase.
- R6: During erase with `susp_req` or `susp_done` set, a read of an erased, unprotected block returns bit 7 equal to `susp_done`. Bit 6 keeps flipping only while `susp_done` is 0, and bit 2 keeps flipping in either case.
- R7: During suspended erase, a read of a block not being erased, or of a protected block, returns `array_data` and leaves both toggle states unchanged.
- R8: In program and erase status, bit 5 equals `fail`.
- R9: A `buf_abort` pulse latches abort status from the next cycle. While it is latched, reads return program-style status with bit 1 set, even if the operation becomes idle. An `abort_rst` pulse clears the latch and returns the block to read mode.
- R10: A synchronous reset clears `dq` to 0 and forces read mode. `dq` changes only one cycle after a strobe, and both toggle states clear to 0 while in read mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_stb | input | 1 | Read strobe, one cycle per read |
| rd_blk | input | BLK_W | Block index of the read address |
| erase_map | input | NUM_BLK | Blocks selected for erase |
| prot_map | input | NUM_BLK | Protected blocks |
| op_type | input | 3 | 0 idle, 1 program, 2 buffer program, 3 block erase, 4 chip erase |
| prog_data | input | 8 | Byte being programmed |
| erase_started | input | 1 | Erase engine has started |
| susp_req | input | 1 | Erase suspend requested |
| susp_done | input | 1 | Erase suspend in effect |
| fail | input | 1 | Operation failed |
| buf_abort | input | 1 | Buffer program abort pulse |
| abort_rst | input | 1 | Abort-and-reset command pulse |
| array_data | input | 8 | Array byte at the read address |
| dq | output | 8 | Registered read data |

## Verification
The bench goes after the address-dependent cases: a protected block inside the erase map, a block outside the map during suspend, and the change of bit 7 and bit 6 at the moment suspend takes effect. A design that ignored protection would flip bit 2 on the protected read. A design that kept flipping bit 6 after suspend took effect would give the wrong toggle value on the next read of an erased block. The bench also checks that the abort status outlives a return to idle, and that toggle states restart at 0 after read mode. A design that lost the abort latch would return array data too early, and one that did not clear the toggles would show bit 6 as 1 on the first status read.

// File: rtl/fsr_pkg.sv
package fsr_pkg;

    typedef enum logic [2:0] {
        OP_IDLE    = 3'd0,
        OP_PROG    = 3'd1,
        OP_BUFPROG = 3'd2,
        OP_BERASE  = 3'd3,
        OP_CERASE  = 3'd4
    } op_e;

    typedef enum logic [1:0] {
        V_ARRAY,
        V_PROG,
        V_ERASE
    } view_e;

    typedef struct packed {
        logic poll;
        logic tog;
        logic fail;
        logic rsv4;
        logic etimer;
        logic alt;
        logic abrt;
        logic rsv0;
    } stat_t;

    function automatic logic is_erase(op_e op);
        return (op == OP_BERASE) || (op == OP_CERASE);
    endfunction

    function automatic logic is_prog(op_e op);
        return (op == OP_PROG) || (op == OP_BUFPROG);
    endfunction

endpackage

// File: rtl/fsr_mode_ctl.sv
module fsr_mode_ctl
    import fsr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  op_e  op,
    input  logic buf_abort,
    input  logic abort_rst,
    output logic abort_lat,
    output logic read_mode
);
    always_ff @(posedge clk) begin
        if (rst || abort_rst) begin
            abort_lat <= 1'b0;
        end else if (buf_abort) begin
            abort_lat <= 1'b1;
        end
    end

    assign read_mode = (op == OP_IDLE) && !abort_lat;
endmodule

// File: rtl/fsr_toggle.sv
module fsr_toggle (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic flip,
    output logic q
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            q <= 1'b0;
        end else if (flip) begin
            q <= ~q;
        end
    end
endmodule

// File: rtl/fsr_status_fmt.sv
module fsr_status_fmt
    import fsr_pkg::*;
(
    input  op_e        op,
    input  logic       read_mode,
    input  logic       abort_lat,
    input  logic       in_erase,
    input  logic       susp_req,
    input  logic       susp_done,
    input  logic       erase_started,
    input  logic       fail,
    input  logic [7:0] prog_data,
    input  logic [7:0] array_data,
    input  logic       t6,
    input  logic       t2,
    output logic [7:0] byte_out,
    output logic       flip6,
    output logic       flip2
);
    view_e view;
    stat_t st;
    logic  suspended;

    assign suspended = susp_req || susp_done;

    always_comb begin
        if (read_mode) begin
            view = V_ARRAY;
        end else if (abort_lat || is_prog(op)) begin
            view = V_PROG;
        end else if (is_erase(op)) begin
            view = (suspended && !in_erase) ? V_ARRAY : V_ERASE;
        end else begin
            view = V_ARRAY;
        end
    end

    always_comb begin
        st       = '0;
        st.tog   = t6;
        st.alt   = t2;
        st.fail  = fail;
        st.abrt  = abort_lat;
        flip6    = 1'b0;
        flip2    = 1'b0;
        byte_out = array_data;
        unique case (view)
            V_PROG: begin
                st.poll  = ~prog_data[7];
                flip6    = 1'b1;
                byte_out = st;
            end
            V_ERASE: begin
                st.poll   = susp_done;
                st.etimer = (op == OP_CERASE) ? 1'b1 : erase_started;
                flip6     = !susp_done;
                flip2     = in_erase;
                byte_out  = st;
            end
            default: byte_out = array_data;
        endcase
    end
endmodule

// File: rtl/flash_status_resp.sv
module flash_status_resp
    import fsr_pkg::*;
#(
    parameter int NUM_BLK = 16,
    localparam int BLK_W = (NUM_BLK > 1) ? $clog2(NUM_BLK) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               rd_stb,
    input  logic [BLK_W-1:0]   rd_blk,
    input  logic [NUM_BLK-1:0] erase_map,
    input  logic [NUM_BLK-1:0] prot_map,
    input  logic [2:0]         op_type,
    input  logic [7:0]         prog_data,
    input  logic               erase_started,
    input  logic               susp_req,
    input  logic               susp_done,
    input  logic               fail,
    input  logic               buf_abort,
    input  logic               abort_rst,
    input  logic [7:0]         array_data,
    output logic [7:0]         dq
);
    op_e        op;
    logic       abort_lat;
    logic       read_mode;
    logic       in_erase;
    logic       t6, t2;
    logic       flip6, flip2;
    logic [7:0] byte_out;

    assign op       = op_e'(op_type);
    assign in_erase = erase_map[rd_blk] && !prot_map[rd_blk];

    fsr_mode_ctl u_mode (
        .clk       (clk),
        .rst       (rst),
        .op        (op),
        .buf_abort (buf_abort),
        .abort_rst (abort_rst),
        .abort_lat (abort_lat),
        .read_mode (read_mode)
    );

    fsr_toggle u_tog6 (
        .clk  (clk),
        .rst  (rst),
        .clr  (read_mode),
        .flip (rd_stb && flip6),
        .q    (t6)
    );

    fsr_toggle u_tog2 (
        .clk  (clk),
        .rst  (rst),
        .clr  (read_mode),
        .flip (rd_stb && flip2),
        .q    (t2)
    );

    fsr_status_fmt u_fmt (
        .op            (op),
        .read_mode     (read_mode),
        .abort_lat     (abort_lat),
        .in_erase      (in_erase),
        .susp_req      (susp_req),
        .susp_done     (susp_done),
        .erase_started (erase_started),
        .fail          (fail),
        .prog_data     (prog_data),
        .array_data    (array_data),
        .t6            (t6),
        .t2            (t2),
        .byte_out      (byte_out),
        .flip6         (flip6),
        .flip2         (flip2)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            dq <= 8'h00;
        end else if (rd_stb) begin
            dq <= byte_out;
        end
    end
endmodule

// File: rtl/fsr_checker.sv
module fsr_checker (
    input logic       clk,
    input logic       rst,
    input logic       rd_stb,
    input logic [2:0] op_type,
    input logic [7:0] prog_data,
    input logic       fail,
    input logic [7:0] array_data,
    input logic       buf_abort,
    input logic       abort_rst,
    input logic       susp_req,
    input logic       susp_done,
    input logic       abort_lat,
    input logic [7:0] dq
);
    assert_readmode_R1: assert property (@(posedge clk) disable iff (rst)
        rd_stb && op_type == 3'd0 && !abort_lat |=> dq == $past(array_data));

    assert_prog_poll_R2: assert property (@(posedge clk) disable iff (rst)
        rd_stb && (op_type == 3'd1 || op_type == 3'd2)
        |=> dq[7] == !$past(prog_data[7]) && dq[4] == 1'b0 && dq[0] == 1'b0);

    assert_erase_poll_R4: assert property (@(posedge clk) disable iff (rst)
        rd_stb && (op_type == 3'd3 || op_type == 3'd4) && !susp_req && !susp_done && !abort_lat
        |=> dq[7] == 1'b0);

    assert_fail_bit_R8: assert property (@(posedge clk) disable iff (rst)
        rd_stb && (op_type == 3'd1 || op_type == 3'd2) |=> dq[5] == $past(fail));

    assert_abort_set_R9: assert property (@(posedge clk) disable iff (rst)
        buf_abort && !abort_rst |=> abort_lat);

    assert_abort_clr_R9: assert property (@(posedge clk) disable iff (rst)
        abort_rst |=> !abort_lat);

    assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !rd_stb |=> $stable(dq));
endmodule

bind flash_status_resp fsr_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .rd_stb     (rd_stb),
    .op_type    (op_type),
    .prog_data  (prog_data),
    .fail       (fail),
    .array_data (array_data),
    .buf_abort  (buf_abort),
    .abort_rst  (abort_rst),
    .susp_req   (susp_req),
    .susp_done  (susp_done),
    .abort_lat  (abort_lat),
    .dq         (dq)
);

// File: tb/flash_status_resp_tb.sv
module flash_status_resp_tb;
    localparam int NB = 16;
    localparam int BW = $clog2(NB);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          rd_stb = 1'b0;
    logic [BW-1:0] rd_blk = '0;
    logic [NB-1:0] erase_map = '0;
    logic [NB-1:0] prot_map = '0;
    logic [2:0]    op_type = 3'd0;
    logic [7:0]    prog_data = 8'h00;
    logic          erase_started = 1'b0;
    logic          susp_req = 1'b0;
    logic          susp_done = 1'b0;
    logic          fail = 1'b0;
    logic          buf_abort = 1'b0;
    logic          abort_rst = 1'b0;
    logic [7:0]    array_data = 8'h00;
    logic [7:0]    dq;

    always #10 clk = ~clk;

    flash_status_resp #(.NUM_BLK(NB)) u_dut (
        .clk(clk), .rst(rst), .rd_stb(rd_stb), .rd_blk(rd_blk),
        .erase_map(erase_map), .prot_map(prot_map), .op_type(op_type),
        .prog_data(prog_data), .erase_started(erase_started),
        .susp_req(susp_req), .susp_done(susp_done), .fail(fail),
        .buf_abort(buf_abort), .abort_rst(abort_rst),
        .array_data(array_data), .dq(dq)
    );

    typedef struct {
        logic [7:0] exp;
        string      tag;
    } item_t;

    item_t q[$];
    int    errors = 0;
    int    checks = 0;
    bit    done = 1'b0;
    logic  stb_d = 1'b0;
    logic  m_t6 = 1'b0, m_t2 = 1'b0, m_abort = 1'b0;

    always @(posedge clk) stb_d <= rd_stb;

    always @(negedge clk) begin
        if (stb_d && q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            checks++;
            if (dq !== it.exp) begin
                errors++;
                $display("FAIL %s: dq=%02h expected=%02h", it.tag, dq, it.exp);
            end
        end
    end

    function automatic logic model_rm();
        return op_type == 3'd0 && !m_abort;
    endfunction

    task automatic rd(input int blk, input logic [7:0] arr, input string tag);
        logic [7:0] e;
        logic       ie, sus, isp, ise;
        @(negedge clk);
        rd_blk = blk[BW-1:0];
        array_data = arr;
        ie  = erase_map[blk] && !prot_map[blk];
        sus = susp_req || susp_done;
        isp = op_type == 3'd1 || op_type == 3'd2;
        ise = op_type == 3'd3 || op_type == 3'd4;
        if (model_rm()) begin
            m_t6 = 0; m_t2 = 0; e = arr;
        end else if (m_abort || isp) begin
            e = {~prog_data[7], m_t6, fail, 1'b0, 1'b0, m_t2, m_abort, 1'b0};
            m_t6 = ~m_t6;
        end else if (ise && !(sus && !ie)) begin
            e = {susp_done, m_t6, fail, 1'b0,
                 (op_type == 3'd4) ? 1'b1 : erase_started, m_t2, 1'b0, 1'b0};
            if (!susp_done) m_t6 = ~m_t6;
            if (ie) m_t2 = ~m_t2;
        end else begin
            e = arr;
        end
        rd_stb = 1'b1;
        q.push_back('{exp: e, tag: tag});
        @(negedge clk);
        rd_stb = 1'b0;
    endtask

    task automatic set_op(input logic [2:0] op);
        @(negedge clk);
        op_type = op;
        if (model_rm()) begin m_t6 = 0; m_t2 = 0; end
        @(negedge clk);
    endtask

    task automatic direct(input logic [7:0] exp, input string tag);
        checks++;
        if (dq !== exp) begin
            errors++;
            $display("FAIL %s: dq=%02h expected=%02h", tag, dq, exp);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: dq=%02h expected=done", dq);
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        direct(8'h00, "R10 reset value");
        rst = 1'b0;
        @(negedge clk);

        rd(0, 8'hA5, "R1 read mode");
        rd(7, 8'h3C, "R1 read mode second");
        @(negedge clk);
        array_data = 8'hFF;
        repeat (3) @(negedge clk);
        direct(8'h3C, "R10 hold without strobe");

        // program status, poll and toggle
        prog_data = 8'h80;
        set_op(3'd1);
        rd(1, 8'h11, "R2 R3 program first read");
        rd(1, 8'h11, "R3 program toggle");
        prog_data = 8'h00;
        fail = 1'b1;
        rd(9, 8'h11, "R2 R8 program fail");
        fail = 1'b0;
        set_op(3'd0);
        rd(2, 8'h5A, "R1 back to read mode");

        // block erase
        erase_map = 16'h0024;
        prot_map  = 16'h0020;
        set_op(3'd3);
        rd(2, 8'h00, "R4 R5 erase before start");
        erase_started = 1'b1;
        rd(2, 8'h00, "R4 R5 erase started");
        rd(3, 8'h00, "R4 erase outside map");
        rd(5, 8'h00, "R4 protected block no alt flip");
        rd(2, 8'h00, "R4 alt toggle inside");
        fail = 1'b1;
        rd(2, 8'h00, "R8 erase fail");
        fail = 1'b0;

        // suspend
        susp_req = 1'b1;
        rd(2, 8'h00, "R6 suspend pending");
        rd(3, 8'h77, "R7 suspend outside block");
        rd(5, 8'h66, "R7 suspend protected block");
        susp_done = 1'b1;
        rd(2, 8'h00, "R6 suspend in effect");
        rd(2, 8'h00, "R6 toggle stopped");
        susp_req = 1'b0;
        susp_done = 1'b0;

        // chip erase
        set_op(3'd4);
        erase_started = 1'b0;
        rd(2, 8'h00, "R5 chip erase timer bit");
        set_op(3'd0);
        rd(4, 8'hC3, "R1 R10 read mode after erase");

        // buffer abort
        prog_data = 8'hFF;
        set_op(3'd2);
        @(negedge clk);
        buf_abort = 1'b1;
        @(negedge clk);
        buf_abort = 1'b0;
        m_abort = 1'b1;
        rd(0, 8'h12, "R9 abort status");
        set_op(3'd0);
        rd(0, 8'h12, "R9 abort survives idle");
        @(negedge clk);
        abort_rst = 1'b1;
        @(negedge clk);
        abort_rst = 1'b0;
        m_abort = 1'b0;
        rd(0, 8'h34, "R9 abort reset to read mode");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule